// File: doc/BRIEF.md
# Isochronous Receive Header Stripper

This block sits between the link-layer receive path and the buffer that stores received DV stream data. Each isochronous packet arrives as a stream of 32-bit quadlets with start and end markers. The first three quadlets always arrive in a fixed order: the isochronous packet header, then CIP0, then CIP1 (which carries the timestamp). After them come the two DV H0 quadlets, and then the payload. Three independent strip enables select which of the first three quadlets are dropped. All other quadlets pass through unchanged, in order, to a write-enabled output stream.

The strip enables are captured on the start-of-packet beat. They apply to that whole packet, so a configuration change never takes effect part-way through a packet. The block also counts the quadlets that are written to the downstream buffer and not yet read by the host. It raises an available flag whenever at least one quadlet is pending.

Top module: `iso_hdr_stripper`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, out_we_o and avail_o are 0.
- R2: When strip_en_i[0] is 1 on the start beat, the quadlet at position 0 (the isochronous header) is not written.
- R3: When strip_en_i[1] is 1 on the start beat, the quadlet at position 1 (CIP0) is not written.
- R4: When strip_en_i[2] is 1 on the start beat, the quadlet at position 2 (CIP1/timestamp) is not written.
- R5: The quadlets at positions 3 and 4 (the H0 pair) are always written, whatever the strip enables.
- R6: Every quadlet that is not stripped appears on out_data_o unchanged, in arrival order, with out_we_o high exactly one cycle after its input beat.
- R7: strip_en_i is sampled only on the beat where in_sop_i is high. Changes to it later in the same packet have no effect on that packet.
- R8: A beat with in_eop_i high ends the packet whatever its length. The next beat is treated as position 0, so a packet cut short leaves no position state behind.
- R9: avail_o is high exactly when the pending count is nonzero. A write raises the count, and the flag, from the following cycle. A buf_rd_i pulse lowers the count by one. A read at a count of zero is ignored. The count saturates at BUF_DEPTH (default 64).
- R10: A cycle with in_valid_i low causes no write one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input quadlet valid |
| in_sop_i | input | 1 | First quadlet of a packet |
| in_eop_i | input | 1 | Last quadlet of a packet |
| in_data_i | input | DATA_W | Input quadlet |
| strip_en_i | input | 3 | Strip enables: bit 0 iso header, bit 1 CIP0, bit 2 CIP1 |
| buf_rd_i | input | 1 | Host pops one quadlet from the downstream buffer |
| out_we_o | output | 1 | Write enable to the downstream buffer |
| out_data_o | output | DATA_W | Quadlet to store |
| avail_o | output | 1 | At least one quadlet pending |

## Verification
On every cycle, the assertions check the following. A stripped header position never produces a write. The H0 positions and the payload always produce a write, one cycle later, carrying the same data. An idle cycle never produces a write. A write always leaves the available flag set. To do this, the checker keeps its own position counter and its own copy of the sampled enables. Some behaviour can only be shown by the bench scenarios: the exact order of the quadlets, enables being ignored when they change mid-packet, recovery after a packet cut short, the one-cycle delay of the available flag, the saturation of the pending count, and reads at zero being ignored.

// File: rtl/iso_strip_pkg.sv
package iso_strip_pkg;
  localparam int unsigned QUAD_W   = 32;
  localparam int unsigned HDR_N    = 3;   // strippable leading positions
  localparam int unsigned H0_N     = 2;   // protected positions after them
  localparam int unsigned DEPTH    = 64;  // downstream buffer depth
  typedef logic [HDR_N-1:0] strip_mask_t;
endpackage

// File: rtl/iso_pos_tracker.sv
module iso_pos_tracker #(
  parameter int unsigned POS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sop_i,
  input  logic             eop_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] cnt_q, cnt_d;

  // start beat always maps to position 0
  assign pos_o = sop_i ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (beat_i) begin
      if (eop_i)                 cnt_d = '0;
      else if (pos_o != POS_MAX) cnt_d = pos_o + 1'b1;
      else                       cnt_d = POS_MAX;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/iso_strip_mask.sv
module iso_strip_mask #(
  parameter int unsigned HDR_N = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sop_i,
  input  logic [HDR_N-1:0] en_i,
  output logic [HDR_N-1:0] mask_o
);
  logic [HDR_N-1:0] held_q;
  logic             take;

  assign take   = beat_i && sop_i;
  assign mask_o = take ? en_i : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (take) held_q <= en_i;
  end
endmodule

// File: rtl/iso_out_stage.sv
module iso_out_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      data_o <= '0;
    end else begin
      we_o <= we_i;
      if (we_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/iso_avail_cnt.sv
module iso_avail_cnt #(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic rd_i,
  output logic avail_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] pend_q;
  logic          inc, dec;

  assign inc     = wr_i && (pend_q != FULL);
  assign dec     = rd_i && (pend_q != '0);
  assign avail_o = (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      unique case ({inc, dec})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end
endmodule

// File: rtl/iso_hdr_stripper.sv
module iso_hdr_stripper
  import iso_strip_pkg::*;
#(
  parameter int unsigned DATA_W    = QUAD_W,
  parameter int unsigned HDR_Q     = HDR_N,
  parameter int unsigned H0_Q      = H0_N,
  parameter int unsigned BUF_DEPTH = DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [HDR_Q-1:0]  strip_en_i,
  input  logic              buf_rd_i,
  output logic              out_we_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              avail_o
);
  localparam int unsigned POS_W = $clog2(HDR_Q + H0_Q + 1) + 1;

  logic [POS_W-1:0] pos;
  logic [HDR_Q-1:0] mask;
  logic [HDR_Q-1:0] hit;
  logic             drop;

  iso_pos_tracker #(.POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni,
    .beat_i (in_valid_i),
    .sop_i  (in_sop_i),
    .eop_i  (in_eop_i),
    .pos_o  (pos)
  );

  iso_strip_mask #(.HDR_N(HDR_Q)) u_mask (
    .clk_i, .rst_ni,
    .beat_i (in_valid_i),
    .sop_i  (in_sop_i),
    .en_i   (strip_en_i),
    .mask_o (mask)
  );

  // only the leading HDR_Q positions can be hit; H0 and payload never match
  for (genvar k = 0; k < HDR_Q; k++) begin : g_hit
    assign hit[k] = mask[k] && (pos == POS_W'(k));
  end
  assign drop = |hit;

  iso_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .we_i   (in_valid_i && !drop),
    .data_i (in_data_i),
    .we_o   (out_we_o),
    .data_o (out_data_o)
  );

  iso_avail_cnt #(.DEPTH(BUF_DEPTH)) u_avail (
    .clk_i, .rst_ni,
    .wr_i    (out_we_o),
    .rd_i    (buf_rd_i),
    .avail_o (avail_o)
  );
endmodule

// File: rtl/iso_hdr_stripper_chk.sv
module iso_hdr_stripper_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HDR_Q  = 3,
  parameter int unsigned H0_Q   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_sop_i,
  input logic              in_eop_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic [HDR_Q-1:0]  strip_en_i,
  input logic              buf_rd_i,
  input logic              out_we_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              avail_o
);
  localparam int unsigned LIM = HDR_Q + H0_Q + 1;

  int unsigned      c_cnt;
  int unsigned      c_pos;
  logic [HDR_Q-1:0] c_held;
  logic [HDR_Q-1:0] c_mask;
  logic             c_strip;
  logic             c_h0;

  assign c_pos   = in_sop_i ? 0 : c_cnt;
  assign c_mask  = (in_valid_i && in_sop_i) ? strip_en_i : c_held;
  assign c_strip = (c_pos < HDR_Q) && c_mask[c_pos % HDR_Q];
  assign c_h0    = (c_pos >= HDR_Q) && (c_pos < HDR_Q + H0_Q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_cnt  <= 0;
      c_held <= '0;
    end else if (in_valid_i) begin
      if (in_sop_i) c_held <= strip_en_i;
      if (in_eop_i)         c_cnt <= 0;
      else if (c_pos < LIM) c_cnt <= c_pos + 1;
    end
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (!out_we_o && !avail_o));

  p_strip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && c_pos == 0 && c_mask[0]) |=> !out_we_o);
  p_strip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && c_pos == 1 && c_mask[1]) |=> !out_we_o);
  p_strip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && c_pos == 2 && c_mask[2]) |=> !out_we_o);

  p_h0_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && c_h0) |=> out_we_o);

  p_pass_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !c_strip) |=> (out_we_o && out_data_o == $past(in_data_i)));

  p_avail_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |=> avail_o);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_we_o);
endmodule

bind iso_hdr_stripper iso_hdr_stripper_chk #(
  .DATA_W(DATA_W), .HDR_Q(HDR_Q), .H0_Q(H0_Q)
) u_chk (.*);

// File: tb/tb_iso_hdr_stripper.sv
module tb_iso_hdr_stripper;
  localparam int DW = 32;
  localparam int DEPTH = 64;

  typedef struct {
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [2:0]    strip_en = '0;
  logic          buf_rd = 1'b0;
  logic          out_we, avail;
  logic [DW-1:0] out_data;

  int   total = 0;
  int   bad = 0;
  int   rx_cnt = 0;
  int   exp_pend = 0;
  int   pkt_id = 0;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  iso_hdr_stripper dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_data_i(in_data), .strip_en_i(strip_en), .buf_rd_i(buf_rd),
    .out_we_o(out_we), .out_data_o(out_data), .avail_o(avail)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_we) begin
      rx_cnt++;
      if (sb.size() == 0) begin
        chk(1'b0, "R10 unexpected write", longint'(out_data), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(out_data == e.data, e.tag, longint'(out_data), longint'(e.data));
      end
    end
  end

  task automatic push_exp(input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.data = d;
    e.tag  = tag;
    sb.push_back(e);
    if (exp_pend < DEPTH) exp_pend++;
  endtask

  // drives one packet; enables en_a on the start beat, en_b afterwards
  task automatic send_pkt(input int len, input logic [2:0] en_a, input logic [2:0] en_b,
                          input bit gaps, input string tag);
    int base, want;
    base = rx_cnt;
    want = 0;
    pkt_id++;
    for (int b = 0; b < len; b++) begin
      logic [DW-1:0] d;
      d = {16'(pkt_id), 16'(b)};
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (b == 0);
      in_eop   = (b == len - 1);
      in_data  = d;
      strip_en = (b == 0) ? en_a : en_b;
      if (!(b < 3 && en_a[b])) begin
        push_exp(d, (b == 3 || b == 4) ? "R5" : "R6");
        want++;
      end
      if (gaps && b[0] && b != len - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hdead_0000 | 32'(b);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    @(negedge clk);
    #1;
    chk(rx_cnt - base == want, tag, rx_cnt - base, want);
    chk(!out_we, "R10 idle after packet", out_we, 0);
  endtask

  task automatic drain(input string tag);
    int n;
    n = exp_pend;
    @(negedge clk);
    chk(avail == (n > 0), tag, avail, n > 0);
    for (int i = 0; i < n; i++) begin
      if (i > 0) chk(avail == 1'b1, tag, avail, 1);
      buf_rd = 1'b1;
      @(negedge clk);
    end
    buf_rd = 1'b0;
    chk(avail == 1'b0, tag, avail, 0);
    exp_pend = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_we && !avail, "R1 in reset", {out_we, avail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_we && !avail, "R1 after release", {out_we, avail}, 0);

    send_pkt(8, 3'b000, 3'b000, 1'b0, "R6 no strip");
    send_pkt(8, 3'b001, 3'b001, 1'b0, "R2 iso header");
    send_pkt(8, 3'b010, 3'b010, 1'b0, "R3 cip0");
    send_pkt(8, 3'b100, 3'b100, 1'b0, "R4 cip1");
    send_pkt(10, 3'b111, 3'b111, 1'b1, "R5 all stripped with gaps R10");
    send_pkt(6, 3'b111, 3'b000, 1'b0, "R7 late clear ignored");
    send_pkt(6, 3'b000, 3'b111, 1'b0, "R7 late set ignored");
    send_pkt(2, 3'b110, 3'b110, 1'b0, "R8 short packet");
    send_pkt(1, 3'b111, 3'b111, 1'b0, "R8 single stripped beat");
    send_pkt(7, 3'b011, 3'b011, 1'b0, "R8 after short");
    chk(sb.size() == 0, "R6 leftover expected", sb.size(), 0);
    drain("R9 drain");

    // read at zero is ignored
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
    chk(!avail, "R9 read at zero", avail, 0);

    // single write: flag one cycle after write enable
    @(negedge clk);
    pkt_id++;
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; strip_en = 3'b000;
    in_data = {16'(pkt_id), 16'h0};
    push_exp(in_data, "R6");
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    chk(out_we && !avail, "R9 flag not yet", {out_we, avail}, 2'b10);
    @(negedge clk);
    chk(avail, "R9 flag next cycle", avail, 1);
    drain("R9 single drain");

    // saturation at depth
    send_pkt(70, 3'b000, 3'b000, 1'b0, "R9 overflow stream");
    drain("R9 saturated drain");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R6 final scoreboard", sb.size(), 0);
    finish_run();
  end
endmodule